// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block sits on the host side of a double-buffered, parallel-input DAC. It takes requests over a valid/ready handshake and turns each one into a correctly timed sequence on the converter's pins. The pins are a data bus, an active-low write strobe that captures the bus into the input register, an active-low load strobe that moves the input register into the output register, and an active-low reset pulse. Each request carries a data word and an operation code. The operation is one of four: write only, write then load, one combined pulse on both strobes, or a converter reset.

Every minimum pulse width, setup window and gap is given in nanoseconds as a parameter. It is converted to a whole number of system-clock cycles as the ceiling of the nanosecond value divided by the clock period, and never fewer than one cycle. The data word goes onto the bus on the same clock edge as the write strobe falls. The setup window is therefore covered by stretching the low phase of the write strobe, and the bus holds its value after the strobe rises until the next accepted request.

Top module: `dac_write_seq`

## Requirements
- R1: After reset the bus reads zero, all three strobes are high and ready is high.
- R2: Ready goes low on the cycle after a request is accepted and stays low until every strobe is back high. The busy length in cycles is: write = W; write-then-load = W + G + L; combined = C; reset = T. Here W = max(setup, write width), G = the write-to-load gap, L = the load width, C = max(W, L), and T = the reset width, all in cycles.
- R3: Operation code 2'b00 (write only) drives the bus and pulls the write strobe low on the same edge. The strobe stays low for exactly W cycles, so the data is stable for at least the setup count before the strobe rises.
- R4: When the write strobe rises, the bus carries the accepted word. The word stays on the bus until another request is accepted.
- R5: Operation code 2'b01 (write then load) performs the write of R3. After the write strobe rises, both strobes stay high for exactly G cycles. The load strobe is then low for exactly L cycles.
- R6: Operation code 2'b10 (combined) pulls both strobes low on the same edge and releases them on the same edge, after C cycles.
- R7: Operation code 2'b11 (reset) drives the reset pulse low for exactly T cycles. The bus is left unchanged and neither the write nor the load strobe moves.
- R8: A write-only request never pulls the load strobe low.
- R9: A valid request presented while ready is low is not taken. It produces no strobe and does not change the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Sequencer idle and able to accept |
| reqOp | input | 2 | Operation code (see R3, R5, R6, R7) |
| reqData | input | DATA_W | Word to place on the DAC bus |
| dacData | output | DATA_W | Parallel data bus to the converter |
| dacWrN | output | 1 | Write strobe, active low |
| dacLdN | output | 1 | Load strobe, active low |
| dacRstN | output | 1 | Converter reset pulse, active low |

## Verification
The bench is built with timing minimums that differ from one another: the setup count exceeds the write width and the load width exceeds both. A design that took the wrong maximum, used the write width alone, or shared one width for both strobes would then show a strobe that is one or two cycles short. The bench times the zero-nanosecond gap, which must round up to one idle cycle and must not vanish, and it checks in combined mode that both strobes fall on the same cycle. A reset request carries a non-zero data word, so a sequencer that captured it onto the bus is caught. The bench also holds valid high during a busy phase, which exposes a design that accepts a second request early and shows up as an extra write strobe or a changed bus.

// File: rtl/dac_write_seq_pkg.sv
package dac_write_seq_pkg;

  typedef enum logic [1:0] {
    OP_WRITE      = 2'b00,
    OP_WRITE_LOAD = 2'b01,
    OP_COMBINED   = 2'b10,
    OP_RESET      = 2'b11
  } seqOp_e;

  // strobe commands from control to datapath, valid for the next cycle
  typedef struct packed {
    logic capture;
    logic wrLow;
    logic ldLow;
    logic rstLow;
  } strobeCmd_t;

  function automatic int unsigned nsToCycles(input int unsigned ns, input int unsigned periodNs);
    int unsigned c;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_write_seq_ctrl.sv
module dac_write_seq_ctrl
  import dac_write_seq_pkg::*;
#(
  parameter int unsigned WR_LOW_CYC = 3,
  parameter int unsigned GAP_CYC    = 1,
  parameter int unsigned LD_CYC     = 3,
  parameter int unsigned COMB_CYC   = 3,
  parameter int unsigned RST_CYC    = 3,
  parameter int unsigned CNT_W      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  output logic       reqReady,
  output strobeCmd_t cmd
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WR, ST_GAP, ST_LD, ST_COMB, ST_RST
  } seqState_e;

  seqState_e  state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic       loadAfter, loadAfterNext;
  logic       accept;
  seqOp_e     opIn;

  assign opIn     = seqOp_e'(reqOp);
  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && (state == ST_IDLE);

  always_comb begin
    stateNext     = state;
    cntNext       = cnt;
    loadAfterNext = loadAfter;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          unique case (opIn)
            OP_WRITE: begin
              stateNext     = ST_WR;
              cntNext       = CNT_W'(WR_LOW_CYC - 1);
              loadAfterNext = 1'b0;
            end
            OP_WRITE_LOAD: begin
              stateNext     = ST_WR;
              cntNext       = CNT_W'(WR_LOW_CYC - 1);
              loadAfterNext = 1'b1;
            end
            OP_COMBINED: begin
              stateNext = ST_COMB;
              cntNext   = CNT_W'(COMB_CYC - 1);
            end
            OP_RESET: begin
              stateNext = ST_RST;
              cntNext   = CNT_W'(RST_CYC - 1);
            end
            default: stateNext = ST_IDLE;
          endcase
        end
      end
      ST_WR: begin
        if (cnt == '0) begin
          if (loadAfter) begin
            stateNext = ST_GAP;
            cntNext   = CNT_W'(GAP_CYC - 1);
          end else begin
            stateNext = ST_IDLE;
          end
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt == '0) begin
          stateNext = ST_LD;
          cntNext   = CNT_W'(LD_CYC - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_LD, ST_COMB, ST_RST: begin
        if (cnt == '0) stateNext = ST_IDLE;
        else           cntNext   = cnt - 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // strobes are decoded from the next state so the datapath registers them
  // on the same edge the state changes
  always_comb begin
    cmd.capture = accept && (opIn != OP_RESET);
    cmd.wrLow   = (stateNext == ST_WR) || (stateNext == ST_COMB);
    cmd.ldLow   = (stateNext == ST_LD) || (stateNext == ST_COMB);
    cmd.rstLow  = (stateNext == ST_RST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      loadAfter <= 1'b0;
    end else begin
      state     <= stateNext;
      cnt       <= cntNext;
      loadAfter <= loadAfterNext;
    end
  end

endmodule

// File: rtl/dac_write_seq_datapath.sv
module dac_write_seq_datapath
  import dac_write_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeCmd_t        cmd,
  input  logic [DATA_W-1:0] reqData,
  output logic [DATA_W-1:0] dacData,
  output logic              dacWrN,
  output logic              dacLdN,
  output logic              dacRstN
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacData <= '0;
      dacWrN  <= 1'b1;
      dacLdN  <= 1'b1;
      dacRstN <= 1'b1;
    end else begin
      if (cmd.capture) dacData <= reqData;
      dacWrN  <= ~cmd.wrLow;
      dacLdN  <= ~cmd.ldLow;
      dacRstN <= ~cmd.rstLow;
    end
  end

endmodule

// File: rtl/dac_write_seq.sv
module dac_write_seq
  import dac_write_seq_pkg::*;
#(
  parameter int unsigned DATA_W        = 14,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned SETUP_NS      = 25,
  parameter int unsigned WR_PULSE_NS   = 25,
  parameter int unsigned LD_PULSE_NS   = 25,
  parameter int unsigned RST_PULSE_NS  = 25,
  parameter int unsigned WR_TO_LD_NS   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [DATA_W-1:0] reqData,
  output logic [DATA_W-1:0] dacData,
  output logic              dacWrN,
  output logic              dacLdN,
  output logic              dacRstN
);

  localparam int unsigned SetupCyc = nsToCycles(SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned WrCyc    = nsToCycles(WR_PULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned WrLowCyc = maxOf(SetupCyc, WrCyc);
  localparam int unsigned LdCyc    = nsToCycles(LD_PULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned GapCyc   = nsToCycles(WR_TO_LD_NS, CLK_PERIOD_NS);
  localparam int unsigned RstCyc   = nsToCycles(RST_PULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned CombCyc  = maxOf(WrLowCyc, LdCyc);
  localparam int unsigned MaxCyc   = maxOf(maxOf(CombCyc, GapCyc), RstCyc);
  localparam int unsigned CntW     = (MaxCyc < 2) ? 1 : $clog2(MaxCyc);

  strobeCmd_t cmd;

  dac_write_seq_ctrl #(
    .WR_LOW_CYC(WrLowCyc),
    .GAP_CYC   (GapCyc),
    .LD_CYC    (LdCyc),
    .COMB_CYC  (CombCyc),
    .RST_CYC   (RstCyc),
    .CNT_W     (CntW)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqOp   (reqOp),
    .reqReady(reqReady),
    .cmd     (cmd)
  );

  dac_write_seq_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .reqData(reqData),
    .dacData(dacData),
    .dacWrN (dacWrN),
    .dacLdN (dacLdN),
    .dacRstN(dacRstN)
  );

endmodule

// File: rtl/dac_write_seq_chk.sv
module dac_write_seq_chk
  import dac_write_seq_pkg::*;
#(
  parameter int unsigned DATA_W        = 14,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned SETUP_NS      = 25,
  parameter int unsigned WR_PULSE_NS   = 25,
  parameter int unsigned LD_PULSE_NS   = 25,
  parameter int unsigned RST_PULSE_NS  = 25
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [DATA_W-1:0] dacData,
  input logic              dacWrN,
  input logic              dacLdN,
  input logic              dacRstN
);

  localparam int unsigned WrMin  = maxOf(nsToCycles(SETUP_NS, CLK_PERIOD_NS),
                                         nsToCycles(WR_PULSE_NS, CLK_PERIOD_NS));
  localparam int unsigned LdMin  = nsToCycles(LD_PULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned RstLen = nsToCycles(RST_PULSE_NS, CLK_PERIOD_NS);

  logic [15:0] wrRun, ldRun, rstRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrRun  <= '0;
      ldRun  <= '0;
      rstRun <= '0;
    end else begin
      wrRun  <= dacWrN  ? 16'd0 : wrRun  + 16'd1;
      ldRun  <= dacLdN  ? 16'd0 : ldRun  + 16'd1;
      rstRun <= dacRstN ? 16'd0 : rstRun + 16'd1;
    end
  end

  p_idle_strobes_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (dacWrN && dacLdN && dacRstN));

  p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_wr_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacWrN) |-> (wrRun >= 16'(WrMin)));

  p_bus_steady_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!dacWrN && $past(!dacWrN)) |-> $stable(dacData));

  p_bus_at_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacWrN) |-> $stable(dacData));

  p_ld_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacLdN) |-> (ldRun >= 16'(LdMin)));

  p_rst_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacRstN) |-> (rstRun == 16'(RstLen)));

  p_rst_alone_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dacRstN |-> (dacWrN && dacLdN && $stable(dacData)));

endmodule

bind dac_write_seq dac_write_seq_chk #(
  .DATA_W       (DATA_W),
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .SETUP_NS     (SETUP_NS),
  .WR_PULSE_NS  (WR_PULSE_NS),
  .LD_PULSE_NS  (LD_PULSE_NS),
  .RST_PULSE_NS (RST_PULSE_NS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .dacData (dacData),
  .dacWrN  (dacWrN),
  .dacLdN  (dacLdN),
  .dacRstN (dacRstN)
);

// File: tb/dac_write_seq_bench.sv
`timescale 1ns/1ps
module dac_write_seq_bench;

  localparam int CLK_NS   = 10;
  localparam int DW       = 14;
  localparam int SETUP_NS = 30;
  localparam int WR_NS    = 20;
  localparam int LD_NS    = 40;
  localparam int RST_NS   = 25;
  localparam int GAP_NS   = 0;

  function automatic int ceilCyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int SetupC = ceilCyc(SETUP_NS);
  localparam int WrC    = ceilCyc(WR_NS);
  localparam int LowC   = (SetupC > WrC) ? SetupC : WrC;
  localparam int LdC    = ceilCyc(LD_NS);
  localparam int GapC   = ceilCyc(GAP_NS);
  localparam int RstC   = ceilCyc(RST_NS);
  localparam int CombC  = (LowC > LdC) ? LowC : LdC;

  // each entry: {op[1:0], data[13:0]}
  localparam logic [15:0] VEC [7] = '{
    {2'b00, 14'h3FFF},
    {2'b01, 14'h2AAA},
    {2'b10, 14'h1555},
    {2'b11, 14'h0123},
    {2'b00, 14'h2000},
    {2'b01, 14'h0001},
    {2'b10, 14'h0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [1:0] reqOp = 2'b00;
  logic [DW-1:0] reqData = '0;
  logic [DW-1:0] dacData;
  logic dacWrN, dacLdN, dacRstN;

  int total = 0;
  int bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  dac_write_seq #(
    .DATA_W(DW), .CLK_PERIOD_NS(CLK_NS), .SETUP_NS(SETUP_NS),
    .WR_PULSE_NS(WR_NS), .LD_PULSE_NS(LD_NS), .RST_PULSE_NS(RST_NS),
    .WR_TO_LD_NS(GAP_NS)
  ) u_dac_write_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqData(reqData), .dacData(dacData),
    .dacWrN(dacWrN), .dacLdN(dacLdN), .dacRstN(dacRstN)
  );

  // monitor, sampled on the falling edge
  int cyc = 0;
  logic pWr = 1, pLd = 1, pRst = 1, pReady = 1;
  logic [DW-1:0] pBus = '0;
  int wrRun = 0, ldRun = 0, rstRun = 0, busyRun = 0;
  int wrW = 0, ldW = 0, rstW = 0, busySeen = 0;
  int wrFalls = 0, ldFalls = 0, rstFalls = 0;
  int wrFallCyc = 0, ldFallCyc = 0;
  int busStable = 0, setupSeen = 0, gapRun = 0, gapSeen = -1;
  bit gapActive = 0;
  logic [DW-1:0] busAtRise = '0;

  always @(negedge clk) begin
    cyc++;
    if (dacData != pBus) busStable = 1; else busStable++;
    if (!dacWrN) begin
      if (pWr) begin wrFalls++; wrFallCyc = cyc; end
      wrRun++;
      setupSeen = busStable;
    end else if (!pWr) begin
      wrW = wrRun; wrRun = 0; busAtRise = dacData;
      gapActive = 1; gapRun = 1;
    end else if (gapActive && dacLdN) begin
      gapRun++;
    end
    if (!dacLdN) begin
      if (pLd) begin
        ldFalls++; ldFallCyc = cyc;
        if (gapActive) begin gapSeen = gapRun; gapActive = 0; end
      end
      ldRun++;
    end else if (!pLd) begin
      ldW = ldRun; ldRun = 0;
    end
    if (!dacRstN) begin
      if (pRst) rstFalls++;
      rstRun++;
    end else if (!pRst) begin
      rstW = rstRun; rstRun = 0;
    end
    if (!reqReady) busyRun++;
    else if (!pReady) begin busySeen = busyRun; busyRun = 0; end
    pWr = dacWrN; pLd = dacLdN; pRst = dacRstN; pReady = reqReady; pBus = dacData;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input logic [DW-1:0] d);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqOp = op; reqData = d;
    @(negedge clk);
    reqValid = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] busNow;
    int wf, lf;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dacData == '0, "R1 bus", int'(dacData), 0);
    chk(dacWrN && dacLdN && dacRstN, "R1 strobes", int'({dacWrN, dacLdN, dacRstN}), 7);
    chk(reqReady == 1'b1, "R1 ready", int'(reqReady), 1);
    rstN = 1;
    repeat (2) @(negedge clk);

    busNow = '0;
    for (int i = 0; i < 7; i++) begin
      logic [1:0] op;
      logic [DW-1:0] d;
      op = VEC[i][15:14];
      d  = VEC[i][13:0];
      wf = wrFalls; lf = ldFalls;
      issue(op, d);
      waitIdle();
      case (op)
        2'b00: begin
          chk(busySeen == LowC, "R2 busy write", busySeen, LowC);
          chk(wrW == LowC, "R3 write width", wrW, LowC);
          chk(setupSeen >= SetupC, "R3 setup", setupSeen, SetupC);
          chk(busAtRise == d, "R4 bus at rise", int'(busAtRise), int'(d));
          chk(ldFalls == lf, "R8 no load on write", ldFalls - lf, 0);
          busNow = d;
        end
        2'b01: begin
          chk(busySeen == LowC + GapC + LdC, "R2 busy write-load", busySeen, LowC + GapC + LdC);
          chk(wrW == LowC, "R3 write width in write-load", wrW, LowC);
          chk(busAtRise == d, "R4 bus at rise", int'(busAtRise), int'(d));
          chk(gapSeen == GapC, "R5 gap", gapSeen, GapC);
          chk(ldW == LdC, "R5 load width", ldW, LdC);
          busNow = d;
        end
        2'b10: begin
          chk(busySeen == CombC, "R2 busy combined", busySeen, CombC);
          chk(wrFallCyc == ldFallCyc, "R6 same fall", ldFallCyc - wrFallCyc, 0);
          chk(wrW == CombC, "R6 write width", wrW, CombC);
          chk(ldW == CombC, "R6 load width", ldW, CombC);
          chk(setupSeen >= SetupC, "R3 setup in combined", setupSeen, SetupC);
          busNow = d;
        end
        default: begin
          chk(busySeen == RstC, "R2 busy reset", busySeen, RstC);
          chk(rstW == RstC, "R7 reset width", rstW, RstC);
          chk(wrFalls == wf && ldFalls == lf, "R7 no data strobes", (wrFalls - wf) + (ldFalls - lf), 0);
        end
      endcase
      chk(dacData == busNow, "R4 bus held", int'(dacData), int'(busNow));
      chk(dacWrN && dacLdN && dacRstN, "R2 idle strobes", int'({dacWrN, dacLdN, dacRstN}), 7);
    end

    // R9: valid held during busy phase must be ignored
    wf = wrFalls; lf = ldFalls;
    @(negedge clk);
    reqValid = 1; reqOp = 2'b00; reqData = 14'h1234;
    @(negedge clk);
    reqOp = 2'b01; reqData = 14'h0F0F;
    @(negedge clk);
    chk(reqReady == 1'b0, "R9 ready low while busy", int'(reqReady), 0);
    reqValid = 0;
    waitIdle();
    chk(wrFalls - wf == 1, "R9 single write", wrFalls - wf, 1);
    chk(ldFalls == lf, "R9 no load", ldFalls - lf, 0);
    chk(dacData == 14'h1234, "R9 bus kept", int'(dacData), 'h1234);

    // R7: reset request with data leaves bus alone
    issue(2'b11, 14'h3C3C);
    waitIdle();
    chk(dacData == 14'h1234, "R7 bus unchanged by reset", int'(dacData), 'h1234);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule